// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the register numbers held in the decode, execute, memory and writeback stages. From them it chooses where each of the two ALU operands of the instruction in execute comes from. The choices are the register file, the result waiting in the memory stage, or the result waiting in the writeback stage.

It also detects a load in execute whose destination is read by the instruction in decode. For one cycle it then holds the program counter and the fetch/decode register and turns the next execute entry into a bubble by clearing its control bits. The loaded value then reaches the dependent instruction through the writeback bypass. The stall is decided combinationally from the current stage contents, so the bubble is requested in the same cycle that the hazard is present.

The register file writes in the first half of a cycle and reads in the second half. A result in writeback is therefore already visible to decode, and this block does nothing for that case.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When a source register of the execute instruction equals the memory-stage destination, that stage has its write flag set and the destination is not register 0, the operand select is 2'b10 (memory-stage bypass).
- R2: When the memory stage does not qualify under R1, but the writeback stage has its write flag set, a nonzero destination and a destination equal to the source, the operand select is 2'b01 (writeback bypass).
- R3: When both the memory and writeback stages qualify for the same source, the select is 2'b10, because the memory-stage result is the newer one.
- R4: When neither stage qualifies, the select is 2'b00 (register file). This covers a clear write flag, a destination of 0 and a register mismatch. The code 2'b11 is never output.
- R5: A load-use hazard exists when all of the following hold: the execute instruction has both its memory-read and write flags set, its destination is nonzero, and that destination equals the decode rs or the decode rt. When a load-use hazard exists, pc_we=0, ifid_we=0 and idex_bubble=1 in that same cycle.
- R6: With no load-use hazard, pc_we=1, ifid_we=1 and idex_bubble=0.
- R7: Each of the following causes no stall: a load with destination 0, a load with its write flag clear, and a matching execute instruction whose memory-read flag is clear.
- R8: Operand A is selected from the execute rs and operand B from the execute rt, and the two selects are chosen independently.
- R9: A writeback destination that equals a decode source register causes neither a stall nor any change to the execute operand selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded assertions |
| rst_n | input | 1 | Active-low reset, disables the assertions |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| ex_rs | input | 5 | First source register of the execute instruction |
| ex_rt | input | 5 | Second source register of the execute instruction |
| ex_rd | input | 5 | Destination register of the execute instruction |
| ex_memread | input | 1 | Execute instruction reads data memory (load) |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination register of the writeback instruction |
| wb_regwrite | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Operand A source: 00 regfile, 10 memory stage, 01 writeback |
| fwd_b | output | 2 | Operand B source, same encoding as fwd_a |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Clear the control bits loaded into execute |

## Verification
On every cycle, the assertions check three properties of the selects: register 0 never produces a bypass, the memory stage takes priority over writeback, and the unused code 11 never appears. They also check that a detected load-use hazard always drops both write enables together with raising the bubble, and that no stall is raised without a load in execute. The bench scenarios show the value-level results that the assertions cannot. One is the exact select chosen for each mix of matching stages, including independent A and B choices. Others are the absence of a stall for register-0 loads, for loads with the write flag clear and for writeback-to-decode dependences, and the same-cycle timing of the bubble.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // Priority pick: the younger (memory-stage) result wins over writeback.
  function automatic fwd_sel_e pick_fwd(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return FWD_MEM;
    else if (wb_hit) return FWD_WB;
    else             return FWD_RF;
  endfunction
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hzd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_wr,
  input  logic [AW-1:0] wb_rd,
  output fwd_sel_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  assign mem_hit = mem_wr && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign wb_hit  = wb_wr  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
  assign sel     = pick_fwd(mem_hit, wb_hit);

  // R3: newer result has priority
  p_mem_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit && wb_hit) |-> (sel == FWD_MEM));

  // R4: register 0 is never bypassed
  p_zero_no_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == ZERO_REG) |-> (sel == FWD_RF));

  // R4: unused code never appears
  p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel != fwd_sel_e'(2'b11));

  // R1: memory bypass only with a writing memory stage
  p_mem_needs_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_MEM) |-> (mem_wr && mem_rd == src));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          ex_memread,
  input  logic          ex_regwrite,
  input  logic [AW-1:0] ex_rd,
  output logic          hazard
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic is_load;
  logic rs_dep;
  logic rt_dep;

  assign is_load = ex_memread && ex_regwrite && (ex_rd != ZERO_REG);
  assign rs_dep  = (ex_rd == id_rs);
  assign rt_dep  = (ex_rd == id_rt);
  assign hazard  = is_load && (rs_dep || rt_dep);

  // R7: no stall without a memory read in execute
  p_stall_needs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> ex_memread);

  // R7: a register-0 load never stalls
  p_zero_load_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == ZERO_REG) |-> !hazard);
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hazard,
  output logic pc_we,
  output logic ifid_we,
  output logic idex_bubble
);
  assign pc_we       = !hazard;
  assign ifid_we     = !hazard;
  assign idex_bubble = hazard;

  // R5: freeze and bubble always travel together
  p_freeze_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we));

  // R6: front end advances whenever no bubble is injected
  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_bubble |-> (pc_we && ifid_we));
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned AW    = 5,
  parameter int unsigned N_SRC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_memread,
  input  logic          ex_regwrite,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_regwrite,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_regwrite,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble
);
  logic [AW-1:0] ex_src [N_SRC];
  fwd_sel_e      sel    [N_SRC];
  logic          lu_hazard;

  assign ex_src[0] = ex_rs;
  assign ex_src[1] = ex_rt;

  // R8: one independent selector per execute source operand
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    fwd_select #(.AW(AW)) i_fwd (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (ex_src[g]),
      .mem_wr (mem_regwrite),
      .mem_rd (mem_rd),
      .wb_wr  (wb_regwrite),
      .wb_rd  (wb_rd),
      .sel    (sel[g])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  load_use_detect #(.AW(AW)) i_lud (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .ex_memread  (ex_memread),
    .ex_regwrite (ex_regwrite),
    .ex_rd       (ex_rd),
    .hazard      (lu_hazard)
  );

  stall_ctrl i_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .hazard      (lu_hazard),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .idex_bubble (idex_bubble)
  );

  // R9: a writeback destination alone never stalls
  p_wb_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_memread) |-> (pc_we && !idex_bubble));
endmodule

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic       ex_memread, ex_regwrite, mem_regwrite, wb_regwrite;
  logic [1:0] fwd_a, fwd_b;
  logic       pc_we, ifid_we, idex_bubble;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hazard_fwd_unit i_hazard_fwd_unit (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
    .ex_memread(ex_memread), .ex_regwrite(ex_regwrite),
    .mem_rd(mem_rd), .mem_regwrite(mem_regwrite),
    .wb_rd(wb_rd), .wb_regwrite(wb_regwrite),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we),
    .ifid_we(ifid_we), .idex_bubble(idex_bubble)
  );

  // Expected select, written as a case table over qualifying stages.
  function automatic logic [1:0] exp_sel(input logic [4:0] s);
    bit m, w;
    m = mem_regwrite && mem_rd == s && s != 5'd0;
    w = wb_regwrite  && wb_rd  == s && s != 5'd0;
    case ({m, w})
      2'b10, 2'b11: return 2'b10;
      2'b01:        return 2'b01;
      default:      return 2'b00;
    endcase
  endfunction

  function automatic string sel_tag(input logic [4:0] s);
    bit m, w;
    m = mem_regwrite && mem_rd == s && s != 5'd0;
    w = wb_regwrite  && wb_rd  == s && s != 5'd0;
    if (m && w) return "R3";
    if (m)      return "R1";
    if (w)      return "R2";
    return "R4";
  endfunction

  function automatic bit exp_stall();
    if (!(ex_memread && ex_regwrite)) return 1'b0;
    if (ex_rd == 5'd0) return 1'b0;
    return (ex_rd == id_rs) || (ex_rd == id_rt);
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string stall_tag);
    logic [3:0] es;
    chk(sel_tag(ex_rs), {2'b00, fwd_a}, {2'b00, exp_sel(ex_rs)});
    chk(sel_tag(ex_rt), {2'b00, fwd_b}, {2'b00, exp_sel(ex_rt)});
    es = exp_stall() ? 4'b0001 : 4'b0110;
    chk(stall_tag, {1'b0, pc_we, ifid_we, idex_bubble}, es);
  endtask

  task automatic drive(input logic [4:0] irs, irt, ers, ert, erd,
                       input logic emr, erw, input logic [4:0] mrd,
                       input logic mrw, input logic [4:0] wrd, input logic wrw);
    @(negedge clk);
    id_rs = irs; id_rt = irt; ex_rs = ers; ex_rt = ert; ex_rd = erd;
    ex_memread = emr; ex_regwrite = erw; mem_rd = mrd; mem_regwrite = mrw;
    wb_rd = wrd; wb_regwrite = wrw;
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // reset state: nothing qualifies
    chk("R4", {2'b00, fwd_a}, 4'b0000);
    chk("R6", {1'b0, pc_we, ifid_we, idex_bubble}, 4'b0110);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 memory bypass on A
    drive(1, 2, 3, 4, 9, 0, 1, 3, 1, 0, 0); check_all("R6");
    // R2 writeback bypass on B
    drive(1, 2, 3, 4, 9, 0, 1, 7, 1, 4, 1); check_all("R6");
    // R3 both stages match: memory wins
    drive(1, 2, 5, 5, 9, 0, 1, 5, 1, 5, 1); check_all("R6");
    chk("R3", {2'b00, fwd_a}, 4'b0010);
    // R4 register 0 and clear write flags
    drive(1, 2, 0, 6, 9, 0, 1, 0, 1, 6, 0); check_all("R6");
    chk("R4", {fwd_a, fwd_b}, 4'b0000);
    // R8 independent A/B selects
    drive(1, 2, 8, 11, 9, 0, 1, 8, 1, 11, 1); check_all("R6");
    chk("R8", {fwd_a, fwd_b}, 4'b1001);
    // R5 load-use on rs, then on rt
    drive(7, 2, 3, 4, 7, 1, 1, 0, 0, 0, 0); check_all("R5");
    chk("R5", {1'b0, pc_we, ifid_we, idex_bubble}, 4'b0001);
    drive(1, 7, 3, 4, 7, 1, 1, 0, 0, 0, 0); check_all("R5");
    // R7 register-0 load, load with write clear, non-load match
    drive(0, 0, 3, 4, 0, 1, 1, 0, 0, 0, 0); check_all("R7");
    chk("R7", {1'b0, pc_we, ifid_we, idex_bubble}, 4'b0110);
    drive(7, 2, 3, 4, 7, 1, 0, 0, 0, 0, 0); check_all("R7");
    drive(7, 2, 3, 4, 7, 0, 1, 0, 0, 0, 0); check_all("R7");
    // R9 writeback dest equals decode source: no stall, selects unchanged
    drive(12, 13, 3, 4, 9, 0, 1, 0, 0, 12, 1); check_all("R9");
    chk("R9", {1'b0, pc_we, ifid_we, idex_bubble, fwd_a, fwd_b} , {1'b0, 3'b110, 4'b0000});

    // constrained random over a small register range to force matches
    for (int i = 0; i < 600; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
            1'($urandom), $urandom_range(0, 3), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom));
      check_all(exp_stall() ? "R5" : "R6");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule